// File: doc/BRIEF.md
# Daisy-Chain Potentiometer Host Controller

This block is the host side of a three-line serial link (chip select, serial clock, data) that drives a chain of N digital potentiometer devices wired in series. Each device holds a 17-bit word: a stack-select bit and two 8-bit wiper codes. A write transaction moves a 17×N-bit frame from a parallel input into the chain. The devices apply the new settings when chip select drops.

A read transaction releases the data line. The chain's last output is fed back to its first input, so the frame goes once around the loop. The host captures each bit as it passes, and after 17×N clocks the chain holds its original contents again. The serial clock is derived from the system clock. The half-period, the chip-select lead time and the chip-select tail time are parameters given in system-clock cycles. The controller raises each of them to the smallest cycle count that meets the device's timing limits.

A command is a one-cycle `start` pulse qualified by `rd_mode`. The block reports `busy` while it works and pulses `done` when it finishes.

Top module: `potchain_host`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released: `cs`, `sclk`, `sdo_en`, `busy` and `done` are 0, and `rd_data` is all zeros.
- R2: Every transaction produces exactly 17×NDEV rising `sclk` edges while `cs` is high. After a write, the chain holds `wr_data` bit for bit.
- R3: A write sends `wr_data` from bit 17×NDEV−1 down to bit 0. Within device slice d, bit 17d+16 is the stack-select bit, bits 17d+15..17d+8 are the wiper-1 code (MSB first), and bits 17d+7..17d are the wiper-0 code (MSB first). Slice NDEV−1 goes out first and ends up in the device farthest from the host.
- R4: Let HALF = max(HALF_REQ, the cycles needed for a clock period of at least 285.715 ns, for high and low times of at least 50 ns, for a 250 ns return-data delay and for 30 ns of data setup). `sclk` is high for HALF cycles and low for HALF cycles between rises. `cs` rises max(LEAD_REQ, ⌈50 ns⌉ cycles) before the first rise. `cs` stays high max(TAIL_REQ, ⌈50 ns⌉ cycles) after the last fall. `sclk` is never high while `cs` is low.
- R5: In a write, the first bit is on `sdo` from the cycle `cs` rises. Each later bit appears in the cycle `sclk` falls, and `sdo` does not change while `sclk` is high.
- R6: In a read, `sdo_en` stays 0 for the whole transaction, and the chain's contents after the transaction equal its contents before.
- R7: In a read, the bit on `sdi` at each rising `sclk` edge is captured in arrival order, so the first bit ends at bit 17×NDEV−1 of `rd_data` and the layout matches R3. A write leaves `rd_data` unchanged.
- R8: `busy` rises in the cycle after an accepted `start`. It stays high through ⌈125 ns⌉ cycles of `cs` low after the frame. In the cycle `busy` falls, `done` is 1 for exactly that cycle.
- R9: A `start` that arrives while `busy` is high is ignored, including during the closing low-`cs` interval.
- R10: `rd_mode` and `wr_data` are sampled only in the cycle `start` is accepted. Later changes do not affect the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command pulse, accepted when not busy |
| rd_mode | input | 1 | 1 = read back the chain, 0 = write |
| wr_data | input | 17×NDEV | Frame to write, layout per R3 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 17×NDEV | Frame captured by the last read |
| cs | output | 1 | Chain select, active high |
| sclk | output | 1 | Serial clock; devices shift on its rising edge |
| sdo | output | 1 | Serial data toward the chain |
| sdo_en | output | 1 | Drive enable for `sdo`; 0 releases the line |
| sdi | input | 1 | Return data from the end of the chain |

## Verification
The bench builds the block with three devices (51-bit frames), a 4 ns system period, a half-period request of 40 cycles and a tail request of 20 cycles. With these values the requested half-period is larger than the timing minimum of 36 cycles, so the override path is taken. The tail request also wins over its minimum, while the lead time and idle gap fall back to their computed minimums. Three devices make the slice ordering across device boundaries visible, and a frame of 4105 cycles leaves room to issue starts both in the middle of a frame and during the closing low-select interval.

// File: rtl/potchain_pkg.sv
`timescale 1ns/1ps
package potchain_pkg;

    // Bits held by one device in the chain.
    localparam int unsigned DEV_BITS = 17;

    // Device-side timing limits, in picoseconds.
    localparam int unsigned SCLK_MIN_PERIOD_PS = 285715;
    localparam int unsigned SCLK_MIN_PULSE_PS  = 50000;
    localparam int unsigned DATA_SETUP_PS      = 30000;
    localparam int unsigned RET_DELAY_PS       = 250000;
    localparam int unsigned CS_LEAD_PS         = 50000;
    localparam int unsigned CS_TAIL_PS         = 50000;
    localparam int unsigned CS_GAP_PS          = 125000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_TAIL,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic cs;
        logic sclk;
        logic drive;
    } pins_t;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/potchain_span.sv
`timescale 1ns/1ps
// Down-counter that times the length of each phase.
module potchain_span #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len_m1,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len_m1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/potchain_seq.sv
`timescale 1ns/1ps
// Phase sequencer: lead, clock pulses, tail, idle gap.
module potchain_seq
    import potchain_pkg::*;
#(
    parameter int unsigned NB     = 34,
    parameter int unsigned HALF_C = 36,
    parameter int unsigned LEAD_C = 13,
    parameter int unsigned TAIL_C = 13,
    parameter int unsigned GAP_C  = 32,
    parameter int unsigned CW     = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  rd_mode,
    output logic  busy,
    output logic  done,
    output pins_t pins,
    output logic  ld_frame,
    output logic  shift_out,
    output logic  capture
);
    localparam int unsigned BW = $clog2(NB + 1);

    phase_e          phase, nxt;
    logic [BW-1:0]   bits_left;
    logic            rd_q, rd_nxt;
    logic            expire, load, enter_high, cs_n;
    logic [CW-1:0]   len_m1;

    potchain_span #(.CW(CW)) u_span (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .len_m1 (len_m1),
        .expire (expire)
    );

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: if (start)  nxt = PH_LEAD;
            PH_LEAD: if (expire) nxt = PH_HIGH;
            PH_HIGH: if (expire) nxt = (bits_left == '0) ? PH_TAIL : PH_LOW;
            PH_LOW:  if (expire) nxt = PH_HIGH;
            PH_TAIL: if (expire) nxt = PH_GAP;
            PH_GAP:  if (expire) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            PH_LEAD:         len_m1 = CW'(LEAD_C - 1);
            PH_HIGH, PH_LOW: len_m1 = CW'(HALF_C - 1);
            PH_TAIL:         len_m1 = CW'(TAIL_C - 1);
            PH_GAP:          len_m1 = CW'(GAP_C - 1);
            default:         len_m1 = '0;
        endcase
    end

    assign load       = (nxt != phase);
    assign ld_frame   = (phase == PH_IDLE) && start;
    assign enter_high = (nxt == PH_HIGH) && (phase != PH_HIGH);
    assign shift_out  = (nxt == PH_LOW) && (phase == PH_HIGH);
    assign capture    = enter_high && rd_q;
    assign rd_nxt     = (phase == PH_IDLE) ? rd_mode : rd_q;
    assign cs_n       = (nxt == PH_LEAD) || (nxt == PH_HIGH) ||
                        (nxt == PH_LOW)  || (nxt == PH_TAIL);
    assign busy       = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bits_left <= '0;
            rd_q      <= 1'b0;
            done      <= 1'b0;
            pins      <= '0;
        end else begin
            phase      <= nxt;
            done       <= (phase == PH_GAP) && (nxt == PH_IDLE);
            pins.cs    <= cs_n;
            pins.sclk  <= (nxt == PH_HIGH);
            pins.drive <= cs_n && !rd_nxt;
            if (ld_frame) begin
                rd_q      <= rd_mode;
                bits_left <= BW'(NB);
            end else if (enter_high) begin
                bits_left <= bits_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/potchain_shifter.sv
`timescale 1ns/1ps
// Outgoing frame register and incoming capture register.
module potchain_shifter #(
    parameter int unsigned NB = 34
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic          capture,
    input  logic [NB-1:0] wr_data,
    input  logic          sdi,
    output logic          sdo,
    output logic [NB-1:0] rd_data
);
    logic [NB-1:0] tx_q, rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load) begin
                tx_q <= wr_data;
            end else if (shift) begin
                tx_q <= {tx_q[NB-2:0], 1'b0};
            end
            if (capture) begin
                rx_q <= {rx_q[NB-2:0], sdi};
            end
        end
    end

    assign sdo     = tx_q[NB-1];
    assign rd_data = rx_q;
endmodule

// File: rtl/potchain_host.sv
`timescale 1ns/1ps
module potchain_host
    import potchain_pkg::*;
#(
    parameter int unsigned NDEV     = 2,
    parameter int unsigned SYS_PS   = 4000,
    parameter int unsigned HALF_REQ = 0,
    parameter int unsigned LEAD_REQ = 0,
    parameter int unsigned TAIL_REQ = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     rd_mode,
    input  logic [NDEV*DEV_BITS-1:0] wr_data,
    output logic                     busy,
    output logic                     done,
    output logic [NDEV*DEV_BITS-1:0] rd_data,
    output logic                     cs,
    output logic                     sclk,
    output logic                     sdo,
    output logic                     sdo_en,
    input  logic                     sdi
);
    localparam int unsigned NB = NDEV * DEV_BITS;

    localparam int unsigned HALF_MIN = umax(
        umax(cdiv(SCLK_MIN_PERIOD_PS, 2 * SYS_PS), cdiv(SCLK_MIN_PULSE_PS, SYS_PS)),
        umax(cdiv(RET_DELAY_PS, 2 * SYS_PS), cdiv(DATA_SETUP_PS, SYS_PS)));
    localparam int unsigned HALF_C = umax(HALF_REQ, HALF_MIN);
    localparam int unsigned LEAD_C = umax(LEAD_REQ,
        umax(cdiv(CS_LEAD_PS, SYS_PS), cdiv(DATA_SETUP_PS, SYS_PS)));
    localparam int unsigned TAIL_C = umax(TAIL_REQ, cdiv(CS_TAIL_PS, SYS_PS));
    localparam int unsigned GAP_C  = cdiv(CS_GAP_PS, SYS_PS);
    localparam int unsigned MAXLEN = umax(umax(HALF_C, LEAD_C), umax(TAIL_C, GAP_C));
    localparam int unsigned CW     = $clog2(MAXLEN + 1);

    pins_t pins;
    logic  ld_frame, shift_out, capture;

    potchain_seq #(
        .NB     (NB),
        .HALF_C (HALF_C),
        .LEAD_C (LEAD_C),
        .TAIL_C (TAIL_C),
        .GAP_C  (GAP_C),
        .CW     (CW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_mode   (rd_mode),
        .busy      (busy),
        .done      (done),
        .pins      (pins),
        .ld_frame  (ld_frame),
        .shift_out (shift_out),
        .capture   (capture)
    );

    potchain_shifter #(.NB(NB)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (ld_frame),
        .shift   (shift_out),
        .capture (capture),
        .wr_data (wr_data),
        .sdi     (sdi),
        .sdo     (sdo),
        .rd_data (rd_data)
    );

    assign cs     = pins.cs;
    assign sclk   = pins.sclk;
    assign sdo_en = pins.drive;
endmodule

// File: rtl/potchain_host_chk.sv
`timescale 1ns/1ps
module potchain_host_chk #(
    parameter int unsigned NB   = 34,
    parameter int unsigned HALF = 36
) (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic done
);
    int unsigned hi_cnt;
    int unsigned rise_cnt;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= 0;
            rise_cnt <= 0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= sclk;
            hi_cnt <= sclk ? hi_cnt + 1 : 0;
            if (!cs) rise_cnt <= 0;
            else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1;
        end
    end

    // R4
    sclk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> hi_cnt == HALF);

    // R4
    sclk_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> cs);

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs) |-> rise_cnt == NB);

    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdo));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> !$past(busy));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind potchain_host potchain_host_chk #(.NB(NB), .HALF(HALF_C)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cs   (cs),
    .sclk (sclk),
    .sdo  (sdo),
    .busy (busy),
    .done (done)
);

// File: tb/potchain_host_bench.sv
`timescale 1ns/1ps
module potchain_host_bench;
    localparam int NDEV = 3, SYS_PS = 4000, HALF_REQ = 40, LEAD_REQ = 0, TAIL_REQ = 20;
    localparam int NB = 17 * NDEV;

    function automatic int up(input int a, input int b); return (a + b - 1) / b; endfunction
    function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

    localparam int H = mx(HALF_REQ, mx(mx(up(285715, 2 * SYS_PS), up(50000, SYS_PS)),
                                       mx(up(250000, 2 * SYS_PS), up(30000, SYS_PS))));
    localparam int L = mx(LEAD_REQ, mx(up(50000, SYS_PS), up(30000, SYS_PS)));
    localparam int T = mx(TAIL_REQ, up(50000, SYS_PS));
    localparam int G = up(125000, SYS_PS);
    localparam int CLKED = L + (2 * NB - 1) * H;
    localparam int TOT = CLKED + T + G;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, rd_mode = 1'b0;
    logic [NB-1:0] wr_data = '0;
    logic busy, done, cs, sclk, sdo, sdo_en, sdi;
    logic [NB-1:0] rd_data;

    int n_chk = 0, n_err = 0, rises = 0;

    always #2 clk = ~clk;

    potchain_host #(
        .NDEV(NDEV), .SYS_PS(SYS_PS), .HALF_REQ(HALF_REQ),
        .LEAD_REQ(LEAD_REQ), .TAIL_REQ(TAIL_REQ)
    ) u_potchain_host (
        .clk(clk), .rst(rst), .start(start), .rd_mode(rd_mode), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .cs(cs), .sclk(sclk),
        .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi)
    );

    // Behavioural chain of devices with the feedback path closed.
    logic [NB-1:0] chain = {NDEV{17'h08080}};
    logic [NB-1:0] held  = {NDEV{17'h08080}};
    wire dq = sdo_en ? sdo : chain[NB-1];
    assign sdi = chain[NB-1];
    always @(posedge sclk) if (cs) begin chain <= {chain[NB-2:0], dq}; rises++; end
    always @(negedge cs) held <= chain;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model: offset of the current transaction.
    int r_k = 0;
    bit r_act = 0, r_rd = 0;
    logic [NB-1:0] r_wr = '0;
    always @(posedge clk) begin
        if (rst) r_act = 0;
        else if (!(r_act && r_k < TOT) && start) begin
            r_act = 1; r_k = 0; r_rd = rd_mode; r_wr = wr_data;
        end else if (r_act) begin
            if (r_k < TOT) r_k++; else r_act = 0;
        end
    end

    always @(negedge clk) if (!rst) begin
        bit e_busy, e_done, e_cs, e_sclk, e_en;
        int m, idx;
        e_busy = r_act && r_k < TOT;
        e_done = r_act && r_k == TOT;
        e_cs   = e_busy && r_k < CLKED + T;
        m      = r_k - L;
        e_sclk = e_busy && r_k >= L && r_k < CLKED && ((m / H) % 2 == 0);
        e_en   = e_cs && !r_rd;
        check("R8 busy", busy, e_busy);
        check("R8 done", done, e_done);
        check("R4 cs", cs, e_cs);
        check("R4 sclk", sclk, e_sclk);
        check("R6 sdo_en", sdo_en, e_en);
        if (e_en && r_k < CLKED) begin
            idx = (r_k < L) ? 0 : (m / H + 1) / 2;
            if (e_sclk) check("R3 data bit", sdo, r_wr[NB-1-idx]);
            else        check("R5 data setup", sdo, r_wr[NB-1-idx]);
        end
    end

    task automatic wait_done();
        for (int i = 0; i < TOT + 20; i++) begin
            @(negedge clk);
            if (done) return;
        end
        check("R8 done timeout", 64'd0, 64'd1);
    endtask

    task automatic run(input bit rd, input logic [NB-1:0] d);
        @(negedge clk); rd_mode = rd; wr_data = d; start = 1'b1; rises = 0;
        @(negedge clk); start = 1'b0;
        wait_done();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [NB-1:0] a, b, c;
        a = {17'h1A5C3, 17'h0F00F, 17'h13579};
        b = {17'h0ACE1, 17'h15A5A, 17'h1FFFF};
        c = {17'h10000, 17'h00001, 17'h0FF00};

        repeat (4) @(negedge clk);
        // R1 during reset
        check("R1 cs", cs, 0); check("R1 sclk", sclk, 0); check("R1 sdo_en", sdo_en, 0);
        check("R1 busy", busy, 0); check("R1 done", done, 0); check("R1 rd_data", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after release", busy, 0); check("R1 cs after release", cs, 0);

        // Write a, then read back (R2, R3, R7 untouched by write)
        run(0, a);
        check("R2 chain after write", held, a);
        check("R2 rise count", rises, NB);
        check("R7 rd_data kept by write", rd_data, 0);

        run(1, '1);
        check("R7 read capture", rd_data, a);
        check("R6 chain unchanged by read", held, a);
        check("R2 rise count read", rises, NB);

        // Write b with starts while busy (R9) and input changes (R10)
        @(negedge clk); rd_mode = 1'b0; wr_data = b; start = 1'b1; rises = 0;
        @(negedge clk); start = 1'b0;
        repeat (500) @(negedge clk);
        wr_data = ~b; rd_mode = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (cs) @(negedge clk);
        check("R9 still busy in gap", busy, 1);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        check("R10 chain holds sampled frame", held, b);
        check("R9 no extra clocks", rises, NB);
        @(negedge clk);
        check("R9 idle after ignored start", busy, 0);

        run(1, '0);
        check("R7 read capture b", rd_data, b);
        check("R6 chain unchanged b", held, b);

        run(0, c);
        check("R3 slice order c", held, c);
        check("R7 rd_data kept by write c", rd_data, b);
        run(1, '0);
        check("R7 read capture c", rd_data, c);

        summary();
        $finish;
    end
endmodule